// File: doc/BRIEF.md
# Memory Test Pattern Generator and Checker

This block produces the write-data stream for a memory data-bus exercise. It also checks the data that comes back from the memory. A three-bit code picks one of six patterns:

- the low address bits used as data
- full-bus inversion on every beat (hammering)
- a rotating single one
- a rotating single zero
- a rotating group of three adjacent ones
- a pseudo-random sequence

The code is captured while reset is held, so it cannot change during a run.

Two copies of the same sequence engine run inside the block. The write engine steps once for each accepted write beat and presents the current word combinationally. The read engine steps once for each valid read beat and supplies the expected word for that beat. Because the two engines share no state, the reads may trail the writes by any number of cycles. A failing read beat produces a one-cycle pulse and also sets a flag that stays high until the next reset.

Top module: `memtest_patgen`

## Requirements
- R1: The pattern code on `mode_sel` is captured on every clock edge while `rst_n` is low. After `rst_n` goes high, changes on `mode_sel` have no effect on either sequence until the next reset.
- R2: Code 3'b010 selects address mode, in which the word is the low 16 bits of the beat's address (`wr_addr` for writes, `rd_addr` for expected read data). Codes 3'b000 and 3'b001 behave the same way.
- R3: Code 3'b011 selects hammer mode. The first beat is 16'h0000, and every following beat inverts all 16 bits.
- R4: Code 3'b101 selects walking ones. The first beat is 16'h0001, and the single one moves up one bit per beat, wrapping from bit 15 back to bit 0.
- R5: Code 3'b110 selects walking zeros, which is the bitwise complement of the R4 sequence (the first beat is 16'hFFFE).
- R6: Code 3'b100 selects neighbor mode. The first beat is 16'h8003, and the group of three adjacent ones rotates up one bit per beat.
- R7: Code 3'b111 selects the pseudo-random mode. The first beat is the seed 16'hACE1, and each next word is {q[14:0], q[15]^q[13]^q[12]^q[10]}.
- R8: `wr_data` shows the word for the next write beat at all times. The write sequence moves forward only on cycles where `wr_valid` is high.
- R9: The expected-read sequence moves forward only on cycles where `rd_valid` is high, independently of the writes. Reads that trail the writes by any number of cycles therefore stay aligned.
- R10: `mismatch` is high for exactly one cycle, the cycle after a valid read beat whose `rd_data` differs from the expected word. It is low at all other times.
- R11: `err` goes high in the cycle after the first failing read beat and stays high until reset.
- R12: In the cycle after reset is released, `err` and `mismatch` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the pattern code is captured while it is low |
| mode_sel | input | 3 | Pattern code |
| wr_valid | input | 1 | Write beat accepted this cycle |
| wr_addr | input | ADDR_W (24) | Address of the current write beat |
| wr_data | output | DATA_W (16) | Word for the current write beat |
| rd_valid | input | 1 | Read beat valid this cycle |
| rd_addr | input | ADDR_W (24) | Address of the current read beat |
| rd_data | input | DATA_W (16) | Data returned by the memory |
| mismatch | output | 1 | One-cycle pulse after a failing read beat |
| err | output | 1 | Sticky error flag |

## Verification
The bench builds the block with DATA_W = 16 and ADDR_W = 24, using the default tap mask and seed with the pseudo-random variant enabled.

At this width, a 20-beat run carries the rotating patterns across the wrap from bit 15 back to bit 0. The upper eight address bits are set to nonzero values, which shows that only the low bits reach the data.

A behavioural memory echoes the written words back. Each run corrupts one chosen read beat: the first beat, a middle beat, the last beat, or none. This exposes the one-cycle pulse, the stickiness of the flag and the lag between writes and reads.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

   typedef enum logic [2:0] {
      PM_ADDR   = 3'b010,
      PM_HAMMER = 3'b011,
      PM_NEIGH  = 3'b100,
      PM_WALK1  = 3'b101,
      PM_WALK0  = 3'b110,
      PM_PRBS   = 3'b111
   } pat_mode_e;

   // Codes 000 and 001 are undefined and fall back to address mode.
   function automatic pat_mode_e decode_mode(input logic [2:0] code);
      pat_mode_e m;
      case (code)
         3'b011:  m = PM_HAMMER;
         3'b100:  m = PM_NEIGH;
         3'b101:  m = PM_WALK1;
         3'b110:  m = PM_WALK0;
         3'b111:  m = PM_PRBS;
         default: m = PM_ADDR;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/mtp_mode_latch.sv
module mtp_mode_latch
   import mtp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] code_i,
   output pat_mode_e  mode_o
);

   pat_mode_e mode_q;

   // Follows the code while reset is held and freezes once reset is released.
   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= decode_mode(code_i);
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/mtp_seq_gen.sv
module mtp_seq_gen
   import mtp_pkg::*;
#(
   parameter int          DATA_W   = 16,
   parameter logic [15:0] TAPS     = 16'hB400,
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter bit          USE_PRBS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pat_mode_e         mode,
   input  logic              adv,
   input  logic [DATA_W-1:0] addr_lo,
   output logic [DATA_W-1:0] word
);

   localparam logic [DATA_W-1:0] RING_INIT = {{(DATA_W-1){1'b0}}, 1'b1};

   logic              ham_q;
   logic [DATA_W-1:0] ring_q;
   logic [DATA_W-1:0] ring_up;
   logic [DATA_W-1:0] ring_dn;
   logic [DATA_W-1:0] prbs_word;

   assign ring_up = {ring_q[DATA_W-2:0], ring_q[DATA_W-1]};
   assign ring_dn = {ring_q[0], ring_q[DATA_W-1:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ham_q  <= 1'b0;
         ring_q <= RING_INIT;
      end else if (adv) begin
         ham_q  <= ~ham_q;
         ring_q <= ring_up;
      end
   end

   generate
      if (USE_PRBS) begin : g_prbs
         logic [DATA_W-1:0] lfsr_q;
         logic              fb;
         assign fb = ^(lfsr_q & TAPS[DATA_W-1:0]);
         always_ff @(posedge clk) begin
            if (!rst_n)   lfsr_q <= SEED[DATA_W-1:0];
            else if (adv) lfsr_q <= {lfsr_q[DATA_W-2:0], fb};
         end
         assign prbs_word = lfsr_q;
      end else begin : g_no_prbs
         // Without the pseudo-random engine, that mode falls back to address data.
         assign prbs_word = addr_lo;
      end
   endgenerate

   always_comb begin
      case (mode)
         PM_HAMMER: word = {DATA_W{ham_q}};
         PM_WALK1:  word = ring_q;
         PM_WALK0:  word = ~ring_q;
         PM_NEIGH:  word = ring_q | ring_up | ring_dn;
         PM_PRBS:   word = prbs_word;
         default:   word = addr_lo;
      endcase
   end

endmodule

// File: rtl/mtp_compare.sv
module mtp_compare #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] exp_data,
   output logic              mismatch_o,
   output logic              err_o
);

   logic bad;
   logic mis_q;
   logic err_q;

   assign bad = rd_valid && (rd_data != exp_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mis_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         mis_q <= bad;
         err_q <= err_q | bad;
      end
   end

   assign mismatch_o = mis_q;
   assign err_o      = err_q;

endmodule

// File: rtl/memtest_patgen.sv
module memtest_patgen
   import mtp_pkg::*;
#(
   parameter int          DATA_W   = 16,
   parameter int          ADDR_W   = 24,
   parameter logic [15:0] TAPS     = 16'hB400,
   parameter logic [15:0] SEED     = 16'hACE1,
   parameter bit          USE_PRBS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode_sel,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              mismatch,
   output logic              err
);

   generate
      if (DATA_W < 3 || DATA_W > 16) begin : g_bad_width
         $error("DATA_W must lie in 3..16");
      end
      if (ADDR_W < DATA_W) begin : g_bad_addr
         $error("ADDR_W must be at least DATA_W");
      end
      if (USE_PRBS && SEED[DATA_W-1:0] == '0) begin : g_bad_seed
         $error("SEED must be nonzero");
      end
      if (ADDR_W > DATA_W) begin : g_hi_bits
         // Upper address bits play no part in the data.
         logic unused_hi;
         assign unused_hi = ^{wr_addr[ADDR_W-1:DATA_W], rd_addr[ADDR_W-1:DATA_W]};
      end
   endgenerate

   pat_mode_e         act_mode;
   logic [DATA_W-1:0] exp_word;

   mtp_mode_latch u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (mode_sel),
      .mode_o (act_mode)
   );

   mtp_seq_gen #(
      .DATA_W   (DATA_W),
      .TAPS     (TAPS),
      .SEED     (SEED),
      .USE_PRBS (USE_PRBS)
   ) u_wr_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (act_mode),
      .adv     (wr_valid),
      .addr_lo (wr_addr[DATA_W-1:0]),
      .word    (wr_data)
   );

   mtp_seq_gen #(
      .DATA_W   (DATA_W),
      .TAPS     (TAPS),
      .SEED     (SEED),
      .USE_PRBS (USE_PRBS)
   ) u_rd_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (act_mode),
      .adv     (rd_valid),
      .addr_lo (rd_addr[DATA_W-1:0]),
      .word    (exp_word)
   );

   mtp_compare #(.DATA_W(DATA_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .exp_data   (exp_word),
      .mismatch_o (mismatch),
      .err_o      (err)
   );

endmodule

// File: rtl/mtp_checker.sv
module mtp_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mode,
   input logic              wr_valid,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_valid,
   input logic              mismatch,
   input logic              err
);

   a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(mode));

   a_r3_hammer_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b011 && wr_valid) |=> (wr_data == ~$past(wr_data)));

   a_r4_walk1_single: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b101) |-> ($countones(wr_data) == 1));

   a_r5_walk0_single: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'b110) |-> ($countones(wr_data) == DATA_W - 1));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'b010 && !wr_valid) |=> $stable(wr_data));

   a_r10_no_read_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !mismatch);

   a_r11_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |-> err);

   a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

endmodule

bind memtest_patgen mtp_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (act_mode),
   .wr_valid (wr_valid),
   .wr_data  (wr_data),
   .rd_valid (rd_valid),
   .mismatch (mismatch),
   .err      (err)
);

// File: tb/memtest_patgen_test.sv
module memtest_patgen_test;

   localparam int DW = 16;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_sel = 3'b010;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data;
   logic          rd_valid = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data = '0;
   logic          mismatch;
   logic          err;

   int            checks = 0;
   int            fails = 0;
   logic [DW-1:0] expq[$];
   string         cur_req = "R2";
   logic [DW-1:0] mem [64];

   always #5 clk = ~clk;

   memtest_patgen #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
      .mismatch(mismatch), .err(err)
   );

   // Behavioural memory that echoes written words back.
   always @(posedge clk) if (wr_valid) mem[wr_addr[5:0]] <= wr_data;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] rot_up(input logic [DW-1:0] x, input int k);
      logic [DW-1:0] y = x;
      for (int j = 0; j < k; j++) y = {y[DW-2:0], y[DW-1]};
      return y;
   endfunction

   function automatic logic [DW-1:0] model(input logic [2:0] code, input int i, input logic [AW-1:0] a);
      logic [DW-1:0] q;
      case (code)
         3'b011: return (i % 2) ? 16'hFFFF : 16'h0000;
         3'b100: return rot_up(16'h8003, i % 16);
         3'b101: return rot_up(16'h0001, i % 16);
         3'b110: return ~rot_up(16'h0001, i % 16);
         3'b111: begin
            q = 16'hACE1;
            for (int j = 0; j < i; j++) q = {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
            return q;
         end
         default: return a[DW-1:0];
      endcase
   endfunction

   function automatic logic [AW-1:0] beat_addr(input int i);
      return 24'hAB1230 + AW'(i);
   endfunction

   // Monitor: compares every accepted write word with the scoreboard.
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         if (expq.size() == 0) chk(1'b0, "R8", wr_data, 'x);
         else begin
            logic [DW-1:0] e;
            e = expq.pop_front();
            chk(wr_data == e, cur_req, wr_data, e);
         end
      end
   end

   task automatic do_reset(input logic [2:0] code);
      rst_n = 1'b0;
      mode_sel = code;
      wr_valid = 1'b0;
      rd_valid = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(err == 1'b0, "R12", DW'(err), 0);
      chk(mismatch == 1'b0, "R12", DW'(mismatch), 0);
   endtask

   task automatic run(input logic [2:0] code, input int n, input int bad, input string req);
      logic [2:0] eff;
      eff = (code == 3'b000 || code == 3'b001) ? 3'b010 : code;
      cur_req = {"R1/", req};
      do_reset(code);
      // Write phase, with idle cycles and a mode change that must be ignored (R1).
      for (int i = 0; i < n; i++) begin
         if (i == 3) mode_sel = code ^ 3'b111;
         if (i % 5 == 4) begin
            @(posedge clk);
            #1 wr_valid = 1'b0;
            wr_addr = beat_addr(i);
            @(negedge clk);
            chk(wr_data == model(eff, i, beat_addr(i)), "R8", wr_data, model(eff, i, beat_addr(i)));
         end
         @(posedge clk);
         #1 wr_valid = 1'b1;
         wr_addr = beat_addr(i);
         expq.push_back(model(eff, i, beat_addr(i)));
      end
      @(posedge clk);
      #1 wr_valid = 1'b0;
      chk(expq.size() == 0, "R8", DW'(expq.size()), 0);
      repeat (3) @(posedge clk);
      // Read phase, trailing the writes (R9), with one corrupted beat.
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1 rd_valid = 1'b1;
         rd_addr = beat_addr(i);
         rd_data = mem[rd_addr[5:0]] ^ ((i == bad) ? 16'h0100 : 16'h0000);
         @(posedge clk);
         #1 rd_valid = 1'b0;
         @(negedge clk);
         chk(mismatch == (i == bad), "R10/R9", DW'(mismatch), DW'(i == bad));
         chk(err == (bad >= 0 && i >= bad), "R11", DW'(err), DW'(bad >= 0 && i >= bad));
      end
      @(negedge clk);
      chk(mismatch == 1'b0, "R10", DW'(mismatch), 0);
   endtask

   initial begin
      run(3'b010, 20, 5, "R2");
      run(3'b000, 20, -1, "R2");
      run(3'b011, 20, 7, "R3");
      run(3'b101, 20, 0, "R4");
      run(3'b110, 20, 19, "R5");
      run(3'b100, 20, -1, "R6");
      run(3'b111, 20, 10, "R7");
      run(3'b001, 20, 2, "R2");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R8: watchdog expired, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule